// File: doc/BRIEF.md
# Prescaled Compare Interrupt Timer

This block is a periodic interrupt source that sits on a simple register bus. Software loads an 8-bit prescaler reload value and a 16-bit compare value, then sets a run bit. While running, a prescaler counts down one per clock. Each time it reaches zero it reloads and advances a 16-bit up-counting accumulator by one. When that advance would bring the accumulator to the compare value, the accumulator returns to zero and a level interrupt flag is raised.

The flag stays high until software clears it. It can do so by writing to a dedicated clear address or by pulsing the acknowledge input. Stopping the timer freezes both counters where they are. Starting it again reloads the prescaler but keeps the accumulator, so a paused period resumes rather than restarts. With a reload value of zero the accumulator advances on every clock. The interrupt period is then compare × (reload + 1) clocks.

Top module: `tick_timer`

## Requirements
- R1: Writing address 0 with bit 0 set starts the timer and writing it with bit 0 clear stops it. A stopped timer never raises the interrupt.
- R2: The prescaler reload register keeps only bits 7:0 of a write to address 1. A running prescaler steps the accumulator once every reload+1 clocks.
- R3: With a reload value of zero, the accumulator advances on every clock while running.
- R4: An advance whose result would equal the compare value (address 2) leaves the accumulator at zero and raises `irq` on that same edge. From a start write at edge E with the accumulator at zero, `irq` rises at edge E + compare × (reload + 1).
- R5: `irq` stays high until it is cleared, either by any write to address 3 or by `irq_ack` high at a clock edge. A new interrupt on the same edge as a clear wins, and `irq` stays high.
- R6: Stopping holds the accumulator and the prescaler count. A start write reloads the prescaler from its register and leaves the accumulator unchanged.
- R7: A compare value at or below the current accumulator value is reached only after the accumulator passes 65535 and wraps to zero.
- R8: With `rd_en` high, `rdata` shows the last written run bit (address 0, bit 0), reload value (address 1) and compare value (address 2). Every other address reads zero, and `rdata` is zero while `rd_en` is low.
- R9: After synchronous reset the run bit, reload, compare, accumulator and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational, zero when not reading) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Level interrupt flag |

## Verification
The hardest situation to reach from the ports is a compare value lowered beneath the running accumulator. The accumulator must then travel through its whole 16-bit range and wrap before the interrupt fires. The stimulus sets the reload value to zero so the accumulator advances every clock, lets it climb past the new value, and lowers the compare mid-run. The scoreboard then expects the first interrupt exactly 65536 steps after the value that was passed. The pause-and-resume case is reached the same way: by timing the stop write to land mid-prescale, and predicting the later interrupt edge from the frozen counts.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int TT_ADDR_W = 3;
    localparam int TT_DATA_W = 16;
    localparam int TT_PSC_W  = 8;
    localparam int TT_ACC_W  = 16;

    typedef enum logic [2:0] {
        SEL_RUN   = 3'd0,
        SEL_PSC   = 3'd1,
        SEL_CMP   = 3'd2,
        SEL_CLEAR = 3'd3
    } reg_sel_e;

    // Result of one accumulator advance.
    typedef struct packed {
        logic                hit;
        logic [TT_ACC_W-1:0] value;
    } acc_step_t;

    function automatic acc_step_t acc_advance(input logic [TT_ACC_W-1:0] cur,
                                              input logic [TT_ACC_W-1:0] cmp);
        acc_step_t r;
        logic [TT_ACC_W-1:0] inc;
        inc     = cur + 1'b1;
        r.hit   = (inc == cmp);
        r.value = r.hit ? '0 : inc;
        return r;
    endfunction

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = TT_ADDR_W,
    parameter int DATA_W = TT_DATA_W,
    parameter int PSC_W  = TT_PSC_W,
    parameter int ACC_W  = TT_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output logic [PSC_W-1:0]  psc_val,
    output logic [ACC_W-1:0]  cmp_val,
    output logic              start,
    output logic              clr_wr
);

    logic hit_run, hit_psc, hit_cmp, hit_clr;

    always_comb begin
        hit_run = (addr == ADDR_W'(SEL_RUN));
        hit_psc = (addr == ADDR_W'(SEL_PSC));
        hit_cmp = (addr == ADDR_W'(SEL_CMP));
        hit_clr = (addr == ADDR_W'(SEL_CLEAR));
    end

    assign start  = wr_en && hit_run && wdata[0];
    assign clr_wr = wr_en && hit_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            psc_val <= '0;
            cmp_val <= '0;
        end else if (wr_en) begin
            if (hit_run) run     <= wdata[0];
            if (hit_psc) psc_val <= PSC_W'(wdata);
            if (hit_cmp) cmp_val <= ACC_W'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_run)      rdata = DATA_W'(run);
            else if (hit_psc) rdata = DATA_W'(psc_val);
            else if (hit_cmp) rdata = DATA_W'(cmp_val);
        end
    end

    AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_run) |=> (run == $past(wdata[0])));  // R1

    AST_RUN_HELD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit_run) |=> $stable(run));  // R1

endmodule

// File: rtl/tick_timer_prescaler.sv
module tick_timer_prescaler
    import tick_timer_pkg::*;
#(
    parameter int PSC_W = TT_PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic [PSC_W-1:0] psc_val,
    output logic             step
);

    logic [PSC_W-1:0] cnt;

    assign step = run && !start && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= psc_val;
        end else if (run) begin
            if (cnt == '0) cnt <= psc_val;
            else           cnt <= cnt - 1'b1;
        end
    end

    AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt));  // R6

    AST_PSC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == $past(psc_val)));  // R6

    AST_PSC_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));  // R2

endmodule

// File: rtl/tick_timer_accum.sv
module tick_timer_accum
    import tick_timer_pkg::*;
#(
    parameter int ACC_W = TT_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [ACC_W-1:0] cmp_val,
    input  logic             clr,
    output logic             irq
);

    logic [ACC_W-1:0] acc;
    acc_step_t        adv;

    always_comb begin
        adv = acc_advance(TT_ACC_W'(acc), TT_ACC_W'(cmp_val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            irq <= 1'b0;
        end else begin
            if (step) acc <= ACC_W'(adv.value);
            if (step && adv.hit) irq <= 1'b1;
            else if (clr)        irq <= 1'b0;
        end
    end

    AST_ACC_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(acc));  // R6

    AST_IRQ_FROM_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(step));  // R4

    AST_IRQ_ACC_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (acc == '0));  // R4

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);  // R5

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = TT_ADDR_W,
    parameter int DATA_W = TT_DATA_W,
    parameter int PSC_W  = TT_PSC_W,
    parameter int ACC_W  = TT_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              irq_ack,
    output logic              irq
);

    logic             run, start, clr_wr, step;
    logic [PSC_W-1:0] psc_val;
    logic [ACC_W-1:0] cmp_val;

    tick_timer_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .ACC_W(ACC_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .run(run), .psc_val(psc_val),
        .cmp_val(cmp_val), .start(start), .clr_wr(clr_wr)
    );

    tick_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .run(run), .start(start),
        .psc_val(psc_val), .step(step)
    );

    tick_timer_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .step(step), .cmp_val(cmp_val),
        .clr(clr_wr || irq_ack), .irq(irq)
    );

    AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |-> !step);  // R1

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int cyc = 0;
    int n_chk = 0, n_err = 0;
    int last_edge = 0;
    int exp_q[$];
    string tag_q[$];
    logic irq_d = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer u_tick_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Write that takes effect on edge n.
    task automatic wr_at(input int n, input logic [2:0] a, input logic [15:0] d);
        wait_to(n - 1);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        last_edge = n;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_at(cyc + 1, a, d);
    endtask

    task automatic ack_at(input int n);
        wait_to(n - 1);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int expv, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, int'(rdata), expv);
        rd_en = 1'b0;
    endtask

    task automatic expect_irq(input int edge_n, input string req);
        exp_q.push_back(edge_n);
        tag_q.push_back(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Monitor: each rising irq is matched against the next expected edge.
    always @(negedge clk) begin
        if (rst) begin
            irq_d <= 1'b0;
        end else begin
            if (irq && !irq_d) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R1/R4: unexpected irq at edge actual=%0d expected=none", cyc);
                end else begin
                    check(tag_q.pop_front(), cyc, exp_q.pop_front());
                end
            end
            irq_d <= irq;
        end
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=finished", cyc);
        finish_run();
    end

    initial begin
        int e, r, f, g, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 irq", int'(irq), 0);
        rd_chk(3'd0, 0, "R9 run");
        rd_chk(3'd1, 0, "R9 psc");
        rd_chk(3'd2, 0, "R9 cmp");

        // R8 readback
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd5);
        rd_chk(3'd1, 3, "R8 psc");
        rd_chk(3'd2, 5, "R8 cmp");
        rd_chk(3'd5, 0, "R8 unmapped");
        @(negedge clk); addr = 3'd2; #1;
        check("R8 rd_en low", int'(rdata), 0);

        // R4 period, R2 prescale of 3
        wr(3'd0, 16'd1);
        e = last_edge;
        rd_chk(3'd0, 1, "R8 run");
        expect_irq(e + 20, "R4 first period");
        expect_irq(e + 40, "R2 second period");
        wait_to(e + 24);
        check("R5 sticky", int'(irq), 1);
        wr_at(e + 25, 3'd3, 16'd0);
        check("R5 clear write", int'(irq), 0);
        wait_to(e + 41);
        check("R4 irq again", int'(irq), 1);
        ack_at(e + 42);
        check("R5 ack", int'(irq), 0);

        // R6 pause mid-prescale, R1 no irq while stopped
        wr_at(e + 46, 3'd0, 16'd0);
        wait_to(e + 140);
        check("R1 stopped", int'(irq), 0);
        r = e + 150;
        expect_irq(r + 16, "R6 resume");
        wr_at(r, 3'd0, 16'd1);
        wait_to(r + 17);
        check("R6 irq after resume", int'(irq), 1);
        wr_at(r + 18, 3'd0, 16'd0);
        ack_at(r + 20);

        // R3 zero reload, R5 set beats simultaneous clear
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd3);
        f = cyc + 3;
        expect_irq(f + 3, "R3 zero reload");
        wr_at(f, 3'd0, 16'd1);
        ack_at(f + 3);
        check("R5 set wins", int'(irq), 1);
        wr_at(f + 4, 3'd0, 16'd0);
        ack_at(f + 5);
        check("R5 ack after", int'(irq), 0);

        // R7 compare lowered below accumulator (acc = 1 held)
        wr(3'd2, 16'd200);
        g = cyc + 3;
        wr_at(g, 3'd0, 16'd1);
        wr_at(g + 50, 3'd2, 16'd20);
        expect_irq(g + 65555, "R7 wrap");
        wait_to(g + 65557);
        check("R7 pending", exp_q.size(), 0);

        // R2 8-bit reload, full 256-clock prescale
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 irq after reset", int'(irq), 0);
        wr(3'd1, 16'h01FF);
        rd_chk(3'd1, 255, "R2 width");
        wr(3'd2, 16'd2);
        wr(3'd0, 16'd1);
        h = last_edge;
        expect_irq(h + 512, "R2 reload 255");
        wait_to(h + 515);
        check("R2 pending", exp_q.size(), 0);

        finish_run();
    end

endmodule